// File: doc/BRIEF.md
# Cascadable Shift-and-Store Open-Drain Driver

This block takes a serial bit stream clocked in by a slow external shift clock, shifts it through a chain of stages, and copies the chain into a storage register whenever a strobe is high. The storage register drives a row of open-drain style outputs. Each output is given as a drive-enable bit and a pin level. The output enable gates the drivers, and a stored 1 sinks the line.

Two serial taps let several blocks be chained. The rising tap updates on each rising shift-clock edge. The falling tap updates half a shift-clock period later, on the falling edge. The falling tap suits chains whose clock edges are slow.

The whole block runs on one system clock. The shift clock, serial data, strobe and output enable are asynchronous to it, so each passes through a synchronizer. The shift clock is then turned into rising- and falling-edge pulses.

Top module: `shstore_od_drv`

## Requirements
- R1: The shift chain has STAGES (default 12) stages. On each rising shift-clock edge every stage moves up by one, and the synchronized serial data enters stage 0.
- R2: While the synchronized strobe is high, the storage register reloads from the shift chain on every system clock. While it is low, the storage register keeps its contents through any number of shifts.
- R3: While the synchronized output enable is low, every `drive_en_o` bit is 0 and every `pin_lvl_o` bit is 1 (all lines off), whatever is stored.
- R4: While the synchronized output enable is high, `drive_en_o[i]` equals storage bit i, and `pin_lvl_o[i]` is its inverse. A stored 1 sinks line i (enabled, level 0). A stored 0 leaves the line off.
- R5: On each rising shift-clock edge, `casc_rise_o` takes the value that stage STAGES-2 held just before that edge. It does not change at any other time.
- R6: On each falling shift-clock edge, `casc_fall_o` takes the value that stage STAGES-1 held just before that edge. It holds on rising edges.
- R7: Neither cascade output depends on the strobe or the output enable.
- R8: A synchronous active-high reset clears the synchronizers, the shift chain, the storage register and both cascade outputs. After reset all lines are off.
- R9: Each asynchronous input passes SYNC_DEPTH (default 2) flops. With inputs changed between system-clock edges, output enable reaches the outputs at the 2nd system-clock edge after the change. A shift-clock edge, or a strobe that has gone high, acts on the state at the 3rd edge after the change.
- R10: When two blocks share the shift clock and the second block's serial input is the first block's `casc_fall_o`, they form one 2*STAGES-stage chain. After 2*STAGES shifts, stage j of the first block holds bit 2*STAGES-1-j of the sent sequence, and stage j of the second holds bit STAGES-1-j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sdata_i | input | 1 | Serial data, asynchronous |
| sclk_i | input | 1 | Shift clock, asynchronous level sampled by clk_i |
| strobe_i | input | 1 | Storage strobe, level sensitive, asynchronous |
| oe_i | input | 1 | Output enable, asynchronous |
| drive_en_o | output | STAGES | Per-line driver enable (1 = sinking) |
| pin_lvl_o | output | STAGES | Level to place on a line when enabled (0 when sinking, 1 when off) |
| casc_rise_o | output | 1 | Cascade tap updated on rising shift-clock edges |
| casc_fall_o | output | 1 | Cascade tap updated on falling shift-clock edges |

## Verification
The bench chains two instances through the falling tap. It checks that a bit crosses the boundary exactly once per shift. A tap that sampled the wrong stage, or updated on the wrong edge, would duplicate or drop a bit, and the second block's outputs would then be off by one position. The bench loads a pattern and turns the output enable on while the strobe is low, then shifts more bits. A storage stage that followed the chain regardless of the strobe would show the new bits. The bench also holds the strobe high during shifts, so a storage stage that captured only on the strobe's edge would freeze. Output-enable latency is sampled at the exact edge, and a design that skipped or added a synchronizer stage would switch one cycle early or late.

// File: rtl/shs_pkg.sv
package shs_pkg;
  // Bundle of the asynchronous control and data inputs after synchronization.
  typedef struct packed {
    logic sclk;
    logic sdat;
    logic strobe;
    logic oe;
  } shs_ctl_t;

  localparam int SHS_CTL_W = $bits(shs_ctl_t);
endpackage

// File: rtl/shs_sync.sv
module shs_sync #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stg_q[g] <= '0;
        else       stg_q[g] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i) begin
        if (rst_i) stg_q[g] <= '0;
        else       stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/shs_edge.sv
module shs_edge (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b0;
    else       prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/shs_shift_core.sv
module shs_shift_core #(
  parameter int STAGES = 12
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  output logic [STAGES-1:0] chain_o,
  output logic              tap_rise_o,
  output logic              tap_fall_o
);
  localparam int LAST = STAGES - 1;
  localparam int PRE  = STAGES - 2;

  logic [STAGES-1:0] chain_q;
  logic              tap_r_q;
  logic              tap_f_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      chain_q <= '0;
      tap_r_q <= 1'b0;
    end else if (rise_i) begin
      chain_q <= {chain_q[PRE:0], din_i};
      tap_r_q <= chain_q[PRE];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       tap_f_q <= 1'b0;
    else if (fall_i) tap_f_q <= chain_q[LAST];
  end

  assign chain_o    = chain_q;
  assign tap_rise_o = tap_r_q;
  assign tap_fall_o = tap_f_q;
endmodule

// File: rtl/shs_store_drv.sv
module shs_store_drv #(
  parameter int STAGES = 12
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              strobe_i,
  input  logic              oe_i,
  input  logic [STAGES-1:0] chain_i,
  output logic [STAGES-1:0] store_o,
  output logic [STAGES-1:0] drive_en_o,
  output logic [STAGES-1:0] pin_lvl_o
);
  logic [STAGES-1:0] store_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)         store_q <= '0;
    else if (strobe_i) store_q <= chain_i;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_line
    assign drive_en_o[g] = oe_i & store_q[g];
    assign pin_lvl_o[g]  = ~(oe_i & store_q[g]);
  end

  assign store_o = store_q;
endmodule

// File: rtl/shstore_od_drv.sv
module shstore_od_drv #(
  parameter int STAGES     = 12,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              strobe_i,
  input  logic              oe_i,
  output logic [STAGES-1:0] drive_en_o,
  output logic [STAGES-1:0] pin_lvl_o,
  output logic              casc_rise_o,
  output logic              casc_fall_o
);
  import shs_pkg::*;

  shs_ctl_t          raw_ctl;
  shs_ctl_t          syn_ctl;
  logic              sclk_rise;
  logic              sclk_fall;
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] store_q;

  assign raw_ctl = '{sclk: sclk_i, sdat: sdata_i, strobe: strobe_i, oe: oe_i};

  shs_sync #(.WIDTH(SHS_CTL_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_ctl),
    .q_o   (syn_ctl)
  );

  shs_edge u_edge (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .lvl_i  (syn_ctl.sclk),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  shs_shift_core #(.STAGES(STAGES)) u_core (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rise_i     (sclk_rise),
    .fall_i     (sclk_fall),
    .din_i      (syn_ctl.sdat),
    .chain_o    (chain_q),
    .tap_rise_o (casc_rise_o),
    .tap_fall_o (casc_fall_o)
  );

  shs_store_drv #(.STAGES(STAGES)) u_store (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .strobe_i   (syn_ctl.strobe),
    .oe_i       (syn_ctl.oe),
    .chain_i    (chain_q),
    .store_o    (store_q),
    .drive_en_o (drive_en_o),
    .pin_lvl_o  (pin_lvl_o)
  );
endmodule

// File: rtl/shstore_od_drv_chk.sv
module shstore_od_drv_chk #(
  parameter int STAGES = 12
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              rise_i,
  input logic              fall_i,
  input logic              din_i,
  input logic              strobe_i,
  input logic              oe_i,
  input logic [STAGES-1:0] chain_i,
  input logic [STAGES-1:0] store_i,
  input logic [STAGES-1:0] drive_en_i,
  input logic [STAGES-1:0] pin_lvl_i,
  input logic              c_rise_i,
  input logic              c_fall_i
);
  AST_SHIFT_ON_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_i |=> (chain_i == {$past(chain_i[STAGES-2:0]), $past(din_i)})); // R1

  AST_CHAIN_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !rise_i |=> $stable(chain_i)); // R1

  AST_STORE_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_i |=> (store_i == $past(chain_i))); // R2

  AST_STORE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !strobe_i |=> $stable(store_i)); // R2

  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
    !oe_i |-> (drive_en_i == '0 && pin_lvl_i == '1)); // R3

  AST_LINE_PAIR: assert property (@(posedge clk_i) disable iff (rst_i)
    (drive_en_i & pin_lvl_i) == '0); // R4

  AST_TAP_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_i |=> (c_rise_i == $past(chain_i[STAGES-2]))); // R5

  AST_TAP_RISE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !rise_i |=> $stable(c_rise_i)); // R5

  AST_TAP_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
    fall_i |=> (c_fall_i == $past(chain_i[STAGES-1]))); // R6

  AST_TAP_FALL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !fall_i |=> $stable(c_fall_i)); // R6

  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
    !(rise_i && fall_i)); // R1
endmodule

bind shstore_od_drv shstore_od_drv_chk #(.STAGES(STAGES)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .rise_i     (sclk_rise),
  .fall_i     (sclk_fall),
  .din_i      (syn_ctl.sdat),
  .strobe_i   (syn_ctl.strobe),
  .oe_i       (syn_ctl.oe),
  .chain_i    (chain_q),
  .store_i    (store_q),
  .drive_en_i (drive_en_o),
  .pin_lvl_i  (pin_lvl_o),
  .c_rise_i   (casc_rise_o),
  .c_fall_i   (casc_fall_o)
);

// File: tb/shstore_od_drv_tb_top.sv
module shstore_od_drv_tb_top;
  localparam int N = 12;

  logic clk_i = 1'b0;
  logic rst_i = 1'b1;
  logic sdata = 1'b0;
  logic sclk = 1'b0;
  logic strobe = 1'b0;
  logic oe = 1'b0;

  logic [N-1:0] en0, en1, lvl0, lvl1;
  logic c1_0, c2_0, c1_1, c2_1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  shstore_od_drv #(.STAGES(N)) dut_i (
    .clk_i(clk_i), .rst_i(rst_i), .sdata_i(sdata), .sclk_i(sclk),
    .strobe_i(strobe), .oe_i(oe), .drive_en_o(en0), .pin_lvl_o(lvl0),
    .casc_rise_o(c1_0), .casc_fall_o(c2_0));

  // Second block fed from the first block's falling tap (R10).
  shstore_od_drv #(.STAGES(N)) dut2_i (
    .clk_i(clk_i), .rst_i(rst_i), .sdata_i(c2_0), .sclk_i(sclk),
    .strobe_i(strobe), .oe_i(oe), .drive_en_o(en1), .pin_lvl_o(lvl1),
    .casc_rise_o(c1_1), .casc_fall_o(c2_1));

  // Behavioural reference: input histories sampled at each clock edge.
  logic [3:0] h_sclk, h_stb, h_oe;
  logic [3:0] h_d [2];
  logic [N-1:0] m_sr [2];
  logic [N-1:0] m_st [2];
  logic m_c1 [2];
  logic m_c2 [2];

  always @(posedge clk_i) begin
    if (rst_i) begin
      h_sclk = '0; h_stb = '0; h_oe = '0;
      for (int u = 0; u < 2; u++) begin
        h_d[u] = '0; m_sr[u] = '0; m_st[u] = '0; m_c1[u] = 1'b0; m_c2[u] = 1'b0;
      end
    end else begin
      logic d_second;
      logic rise, fall;
      d_second = m_c2[0];
      h_sclk = {h_sclk[2:0], sclk};
      h_stb  = {h_stb[2:0], strobe};
      h_oe   = {h_oe[2:0], oe};
      h_d[0] = {h_d[0][2:0], sdata};
      h_d[1] = {h_d[1][2:0], d_second};
      rise = h_sclk[2] & ~h_sclk[3];
      fall = ~h_sclk[2] & h_sclk[3];
      for (int u = 0; u < 2; u++) begin
        logic [N-1:0] old;
        old = m_sr[u];
        if (h_stb[2]) m_st[u] = old;
        if (rise) begin
          m_c1[u] = old[N-2];
          m_sr[u] = {old[N-2:0], h_d[u][2]};
        end
        if (fall) m_c2[u] = old[N-1];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the reference (R3 R4 R5 R6 R7 R9).
  always @(negedge clk_i) begin
    if (!rst_i && !done) begin
      logic [N-1:0] e0, e1;
      e0 = h_oe[1] ? m_st[0] : '0;
      e1 = h_oe[1] ? m_st[1] : '0;
      chk(en0 == e0 && lvl0 == ~e0, h_oe[1] ? "R4 line0" : "R3 line0", {en0, lvl0}, {e0, ~e0});
      chk(en1 == e1 && lvl1 == ~e1, h_oe[1] ? "R4 line1" : "R3 line1", {en1, lvl1}, {e1, ~e1});
      chk(c1_0 == m_c1[0] && c1_1 == m_c1[1], "R5 R7 rise tap", {c1_0, c1_1}, {m_c1[0], m_c1[1]});
      chk(c2_0 == m_c2[0] && c2_1 == m_c2[1], "R6 R7 fall tap", {c2_0, c2_1}, {m_c2[0], m_c2[1]});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // One shift-clock period: data set, rise, fall (R1).
  task automatic shift_bit(input logic b);
    sdata = b; cyc(4);
    sclk = 1'b1; cyc(6);
    sclk = 1'b0; cyc(6);
  endtask

  localparam logic [2*N-1:0] PAT = 24'hB4_6E_93;

  initial begin
    logic [N-1:0] x0, x1;
    cyc(3);
    chk(en0 == '0 && en1 == '0 && lvl0 == '1 && c1_0 == 0 && c2_0 == 0, "R8 reset state",
        {en0, c1_0, c2_0}, 0);
    rst_i = 1'b0;
    cyc(2);
    for (int i = 0; i < 2*N; i++) shift_bit(PAT[i]);
    x0 = '0; x1 = '0;
    for (int j = 0; j < N; j++) begin
      x0[j] = PAT[2*N-1-j];
      x1[j] = PAT[N-1-j];
    end
    // Strobe never raised: outputs still show the cleared store (R2).
    oe = 1'b1; cyc(4);
    chk(en0 == '0 && en1 == '0, "R2 hold without strobe", {en0, en1}, 0);
    oe = 1'b0; cyc(4);
    strobe = 1'b1; cyc(4); strobe = 1'b0; cyc(4);
    chk(en0 == '0 && en1 == '0 && lvl1 == '1, "R3 enable low gates lines", {en0, en1}, 0);
    // Output enable latency (R9): off after 1 edge, on after 2.
    oe = 1'b1; cyc(1);
    chk(en0 == '0, "R9 oe one edge", en0, 0);
    cyc(1);
    chk(en0 == x0, "R9 R10 R4 first block", en0, x0);
    chk(en1 == x1, "R10 R1 second block", en1, x1);
    chk(lvl0 == ~x0 && lvl1 == ~x1, "R4 levels", {lvl0, lvl1}, {~x0, ~x1});
    // More shifts with strobe low: lines keep the pattern (R2).
    for (int i = 0; i < 5; i++) shift_bit(i[0]);
    chk(en0 == x0 && en1 == x1, "R2 hold after shifts", {en0, en1}, {x0, x1});
    // Strobe held high while shifting: lines follow the chain (R2).
    strobe = 1'b1;
    for (int i = 0; i < 3; i++) shift_bit(1'b1);
    cyc(2);
    chk(en0[2:0] == 3'b111, "R2 follow with strobe held", en0, 3'b111);
    strobe = 1'b0;
    // Toggle strobe and enable while shifting; taps compared every clock (R7).
    for (int i = 0; i < 6; i++) begin
      oe = i[0]; strobe = i[1];
      shift_bit(i[2] ^ i[0]);
    end
    strobe = 1'b0; oe = 1'b1;
    cyc(4);
    // Mid-run reset (R8).
    rst_i = 1'b1; cyc(2);
    chk(en0 == '0 && en1 == '0 && c1_1 == 0 && c2_1 == 0, "R8 reset mid-run",
        {en0, en1, c1_1, c2_1}, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule